// File: doc/BRIEF.md
# MDIO Link-Up PHY Scanner

This block is a management-bus master that walks a shared MDIO bus looking for a PHY that reports a live link. When it receives a start pulse, it visits PHY addresses in rising order from 0 to 31. At each address it issues two Clause 22 reads of register 1, the basic status register. It then looks at the link status bit of the second read. The first address whose link is up wins, and the scan stops there. If no address qualifies, the block finishes without a selection.

The block produces MDC from the system clock with a programmable divider. The bidirectional MDIO line is handled through three separate signals: a driven value, an output enable and a sampled input. The pad or tristate buffer sits outside the block. The result is shown on three outputs: a done flag, a found flag and the selected 5-bit address. All three hold steady until the next start pulse.

Top module: `mdio_link_scan`

## Requirements
- R1: After an accepted start, the address field steps 0, 0, 1, 1, 2, 2, … from one read frame to the next. Each address gets exactly two frames, and the address never decreases within a scan.
- R2: Every read frame has this fixed layout:
  - 32 preamble bits of value 1;
  - start bits 0 then 1;
  - opcode bits 1 then 0;
  - the 5-bit PHY address, MSB first;
  - the 5-bit register address, which is always 1 (00001).
- R3: The output enable is high for the 46 header bit periods of a frame. It is low for the two turnaround periods, the 16 data periods, and whenever the block is not scanning.
- R4: MDC has a period of 2·CLK_DIV system clocks, with each level lasting CLK_DIV clocks. The driven MDIO value changes only together with a falling MDC edge.
- R5: The block takes each data bit on a rising MDC edge, MSB first. Only the second read at an address decides the link. A first read that shows link up (0x382C) followed by a second read of 0x3808 does not select the address. A first read of 0x3808 followed by a second read of 0x382C does select it.
- R6: The link is up when bit 2 of the status word is 1. A status word of 0xFFFF, meaning no PHY answered, counts as no link even though its bit 2 is set.
- R7: The lowest address with a link-up second read is selected. No read frame is issued after that selection. Addresses below it that return 0x3808 or 0xFFFF do not prevent the selection.
- R8: If address 31 is reached without a link, done rises with found low and the address output at 0. Found is never high while done is low.
- R9: A start pulse accepted while idle clears done and found on the next clock and raises busy. Once done is high, done, found and the address output stay unchanged until the next start pulse, whatever the bus does.
- R10: A start pulse while busy is ignored, and the ongoing scan continues unchanged.
- R11: After reset the block is idle: busy, done and found are 0, the address output is 0, and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a scan from address 0 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value to drive on MDIO |
| mdio_oe | output | 1 | MDIO output enable; when low the line is released |
| mdio_i | input | 1 | Sampled MDIO line |
| busy | output | 1 | High while a scan is in progress |
| done | output | 1 | High once a scan has finished |
| found | output | 1 | High when the finished scan selected a PHY |
| phy_addr | output | 5 | Address of the selected PHY |

## Verification
The bound checker watches several properties on every clock:
- each MDC level lasts exactly CLK_DIV clocks;
- the driven MDIO bit moves only at a falling MDC edge;
- the line is released whenever the block is idle;
- the scan address only ever advances by one inside a scan;
- found implies done;
- the result stays frozen while done is high and no start arrives.

Other behaviours can only be shown by the bench's scenarios. These include which address wins, the decision being based on the second read, absent PHYs being rejected, and the exact frame contents and their count. The bench checks them against a behavioural PHY model that decodes each frame and answers from a per-address table of first and second status words.

// File: rtl/mdio_scan_pkg.sv
package mdio_scan_pkg;

  localparam int PHY_AW     = 5;
  localparam int REG_AW     = 5;
  localparam int DATA_W     = 16;
  localparam int DATA_IW    = $clog2(DATA_W);
  localparam int PRE_LEN    = 32;
  localparam int TA_BITS    = 2;
  localparam int HDR_BITS   = 4 + PHY_AW + REG_AW;
  localparam int HDR_IW     = $clog2(HDR_BITS);
  localparam int DRIVE_BITS = PRE_LEN + HDR_BITS;
  localparam int FRAME_BITS = DRIVE_BITS + TA_BITS + DATA_W;
  localparam int FRAME_IW   = $clog2(FRAME_BITS + 1);

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  typedef enum logic [2:0] {
    SC_IDLE,
    SC_REQ1,
    SC_WAIT1,
    SC_REQ2,
    SC_WAIT2
  } scan_state_e;

  // Header bits that follow the preamble, sent left to right.
  function automatic logic [HDR_BITS-1:0] read_header(
    input logic [PHY_AW-1:0] phy,
    input logic [REG_AW-1:0] regn
  );
    return {SOF_CODE, OP_READ, phy, regn};
  endfunction

  // Value driven during bit period idx of a read frame.
  function automatic logic frame_bit(
    input logic [FRAME_IW-1:0] idx,
    input logic [HDR_BITS-1:0] hdr
  );
    logic [HDR_IW-1:0] pos;
    if (idx < FRAME_IW'(PRE_LEN)) begin
      return 1'b1;
    end
    if (idx < FRAME_IW'(DRIVE_BITS)) begin
      pos = HDR_IW'(DRIVE_BITS - 1 - int'(idx));
      return hdr[pos];
    end
    return 1'b1;
  endfunction

  // A status word of all ones means nobody answered.
  function automatic logic link_up(
    input logic [DATA_W-1:0]  st,
    input logic [DATA_IW-1:0] bitpos
  );
    return (st != '1) && st[bitpos];
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  wire wrap = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Strobes mark the clock edge at which mdc changes level.
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

endmodule

// File: rtl/mdio_read_frame.sv
module mdio_read_frame
  import mdio_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              req,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [FRAME_IW-1:0] LAST_IDX     = FRAME_IW'(FRAME_BITS - 1);
  localparam logic [FRAME_IW-1:0] DRIVE_END    = FRAME_IW'(DRIVE_BITS);
  localparam logic [FRAME_IW-1:0] SAMPLE_START = FRAME_IW'(DRIVE_BITS + TA_BITS);

  logic                active_q;
  logic                armed_q;
  logic [FRAME_IW-1:0] idx_q;
  logic [HDR_BITS-1:0] hdr_q;
  logic [DATA_W-1:0]   shift_q;
  logic                done_q;
  logic                out_q;
  logic                oe_q;

  wire launch   = !active_q && req;
  wire bit_fall = active_q && fall_tick;
  wire bit_rise = active_q && armed_q && rise_tick;
  wire in_data  = (idx_q >= SAMPLE_START);
  wire last_bit = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      idx_q    <= '0;
      hdr_q    <= '0;
      shift_q  <= '0;
      done_q   <= 1'b0;
      out_q    <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        active_q <= 1'b1;
        armed_q  <= 1'b0;
        idx_q    <= '0;
        hdr_q    <= read_header(phy_addr, reg_addr);
      end
      if (bit_fall) begin
        armed_q <= 1'b1;
        out_q   <= frame_bit(idx_q, hdr_q);
        oe_q    <= (idx_q < DRIVE_END);
      end
      if (bit_rise) begin
        if (in_data) begin
          shift_q <= {shift_q[DATA_W-2:0], mdio_i};
        end
        if (last_bit) begin
          active_q <= 1'b0;
          armed_q  <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;
  assign rd_done = done_q;
  assign rd_data = shift_q;

endmodule

// File: rtl/mdio_scan_ctrl.sv
module mdio_scan_ctrl
  import mdio_scan_pkg::*;
#(
  parameter int LINK_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_req,
  output logic [PHY_AW-1:0] cur_addr,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [PHY_AW-1:0] sel_addr
);
  localparam logic [DATA_IW-1:0] LINK_POS  = DATA_IW'(LINK_BIT);
  localparam logic [PHY_AW-1:0]  LAST_ADDR = '1;

  scan_state_e       st_q;
  logic [PHY_AW-1:0] addr_q;
  logic [PHY_AW-1:0] sel_q;
  logic              done_q;
  logic              found_q;

  wire accept_start = (st_q == SC_IDLE) && start;
  wire verdict      = (st_q == SC_WAIT2) && rd_done;
  wire hit          = verdict && link_up(rd_data, LINK_POS);
  wire exhausted    = verdict && !hit && (addr_q == LAST_ADDR);
  wire advance      = verdict && !hit && (addr_q != LAST_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SC_IDLE;
      addr_q  <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
    end else begin
      unique case (st_q)
        SC_IDLE: begin
          if (accept_start) begin
            addr_q  <= '0;
            sel_q   <= '0;
            done_q  <= 1'b0;
            found_q <= 1'b0;
            st_q    <= SC_REQ1;
          end
        end
        SC_REQ1:  st_q <= SC_WAIT1;
        SC_WAIT1: if (rd_done) st_q <= SC_REQ2;
        SC_REQ2:  st_q <= SC_WAIT2;
        SC_WAIT2: begin
          if (hit) begin
            sel_q   <= addr_q;
            found_q <= 1'b1;
            done_q  <= 1'b1;
            st_q    <= SC_IDLE;
          end else if (exhausted) begin
            done_q <= 1'b1;
            st_q   <= SC_IDLE;
          end else if (advance) begin
            addr_q <= addr_q + 1'b1;
            st_q   <= SC_REQ1;
          end
        end
        default: st_q <= SC_IDLE;
      endcase
    end
  end

  assign rd_req   = (st_q == SC_REQ1) || (st_q == SC_REQ2);
  assign cur_addr = addr_q;
  assign busy     = (st_q != SC_IDLE);
  assign done     = done_q;
  assign found    = found_q;
  assign sel_addr = sel_q;

endmodule

// File: rtl/mdio_link_scan.sv
module mdio_link_scan
  import mdio_scan_pkg::*;
#(
  parameter int CLK_DIV    = 50,
  parameter int STATUS_REG = 1,
  parameter int LINK_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [PHY_AW-1:0] phy_addr
);
  localparam logic [REG_AW-1:0] STATUS_ADDR = REG_AW'(STATUS_REG);

  logic              rise_tick;
  logic              fall_tick;
  logic              rd_req;
  logic              rd_done;
  logic [DATA_W-1:0] rd_data;
  logic [PHY_AW-1:0] cur_addr;

  mdio_mdc_gen #(
    .HALF_DIV(CLK_DIV)
  ) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick)
  );

  mdio_read_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick),
    .req      (rd_req),
    .phy_addr (cur_addr),
    .reg_addr (STATUS_ADDR),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_done  (rd_done),
    .rd_data  (rd_data)
  );

  mdio_scan_ctrl #(
    .LINK_BIT(LINK_BIT)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rd_done (rd_done),
    .rd_data (rd_data),
    .rd_req  (rd_req),
    .cur_addr(cur_addr),
    .busy    (busy),
    .done    (done),
    .found   (found),
    .sel_addr(phy_addr)
  );

endmodule

// File: rtl/mdio_link_scan_chk.sv
module mdio_link_scan_chk
  import mdio_scan_pkg::*;
#(
  parameter int HALF_DIV = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              busy,
  input logic              done,
  input logic              found,
  input logic [PHY_AW-1:0] phy_addr,
  input logic [PHY_AW-1:0] cur_addr
);
  logic [15:0] run_len;
  logic        mdc_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
      mdc_d   <= 1'b0;
    end else begin
      mdc_d <= mdc;
      if (mdc != mdc_d) begin
        run_len <= 16'd1;
      end else if (run_len != '1) begin
        run_len <= run_len + 1'b1;
      end
    end
  end

  // R4: each MDC level lasts HALF_DIV clocks
  assert_mdc_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_d) |-> (run_len == 16'(HALF_DIV)));

  // R4: driven bit moves only with a falling MDC edge
  assert_mdo_at_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc));

  // R3: line released while idle
  assert_idle_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R1: scan address only advances by one inside a scan
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(cur_addr)) |-> (cur_addr == $past(cur_addr) + 1'b1));

  // R8: found never without done
  assert_found_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> done);

  // R9: result frozen until a start pulse
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(found) && $stable(phy_addr)));

endmodule

bind mdio_link_scan mdio_link_scan_chk #(
  .HALF_DIV(CLK_DIV)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .busy    (busy),
  .done    (done),
  .found   (found),
  .phy_addr(phy_addr),
  .cur_addr(cur_addr)
);

// File: tb/mdio_link_scan_test.sv
module mdio_link_scan_test;
  localparam int DIV = 4;
  localparam logic [15:0] NOLINK = 16'h3808;
  localparam logic [15:0] LINKUP = 16'h382C;
  localparam logic [15:0] ABSENT = 16'hFFFF;

  logic       clk    = 1'b0;
  logic       rst_n  = 1'b0;
  logic       start  = 1'b0;
  logic       mdio_i = 1'b1;
  logic       mdc, mdio_o, mdio_oe, busy, done, found;
  logic [4:0] phy_addr;

  always #2 clk = ~clk;

  mdio_link_scan #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .busy(busy), .done(done),
    .found(found), .phy_addr(phy_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // PHY table: first and second status answer per address
  logic [15:0] st_first [32];
  logic [15:0] st_second[32];
  int rd_cnt[32];
  int exp_q[$];
  int frames = 0;
  int oe_bad = 0;

  // Behavioural PHY model
  int ph = 0, ones = 0, pre = 0, nb = 0, tcnt = 0;
  logic [12:0] hdr;
  logic [15:0] resp = 16'hFFFF;

  task automatic on_header();
    int a;
    int e;
    a = int'(hdr[9:5]);
    frames++;
    if (exp_q.size() == 0) begin
      chk(0, "R7 frame issued after selection", a, -1);
    end else begin
      e = exp_q.pop_front();
      chk(a == e, "R1 frame address order", a, e);
    end
    chk(hdr[12:10] == 3'b110 && pre == 32, "R2 preamble/start/opcode", pre, 32);
    chk(hdr[4:0] == 5'd1, "R2 register address", int'(hdr[4:0]), 1);
    resp = (rd_cnt[a] == 0) ? st_first[a] : st_second[a];
    rd_cnt[a]++;
  endtask

  always @(posedge mdc) begin
    if (ph == 0) begin
      if (mdio_oe && mdio_o) ones++;
      else if (mdio_oe && !mdio_o && ones >= 32) begin
        pre = ones; ph = 1; nb = 0; hdr = '0;
      end else ones = 0;
    end else if (ph == 1) begin
      if (!mdio_oe) oe_bad++;
      hdr = {hdr[11:0], mdio_o};
      nb++;
      if (nb == 13) begin
        on_header();
        ph = 2; tcnt = 0;
      end
    end else begin
      if (mdio_oe) oe_bad++;
    end
  end

  always @(negedge mdc) begin
    if (ph == 2) begin
      if (tcnt == 0) mdio_i = 1'b1;
      else if (tcnt == 1) mdio_i = (resp == ABSENT);
      else if (tcnt < 18) mdio_i = resp[17 - tcnt];
      else begin mdio_i = 1'b1; ph = 0; ones = 0; end
      tcnt++;
    end
  end

  task automatic fill(input logic [15:0] v);
    for (int a = 0; a < 32; a++) begin st_first[a] = v; st_second[a] = v; end
  endtask

  task automatic run_scan(input string tag, input bit exp_found, input int exp_addr,
                          input bit poke);
    int cyc;
    int early;
    int nexp;
    exp_q.delete();
    for (int a = 0; a < 32; a++) begin
      rd_cnt[a] = 0;
      exp_q.push_back(a); exp_q.push_back(a);
      if (st_second[a] != ABSENT && st_second[a][2]) break;
    end
    nexp = exp_q.size();
    frames = 0; oe_bad = 0; early = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !done && !found, {"R9 start clears result ", tag}, {busy, done, found}, 3'b100);
    if (poke) begin
      repeat (700) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 60000) begin
      if (found) early++;
      @(negedge clk);
      cyc++;
    end
    chk(done, {"R8 scan completes ", tag}, done, 1);
    chk(found == exp_found, {"R7 found flag ", tag}, found, exp_found);
    chk(int'(phy_addr) == exp_addr, {"R7 selected address ", tag}, phy_addr, exp_addr);
    chk(early == 0 && !busy, {"R8 no result before done ", tag}, early, 0);
    repeat (600) @(negedge clk);
    chk(frames == nexp && exp_q.size() == 0, {"R7 frame count ", tag}, frames, nexp);
    chk(oe_bad == 0 && !mdio_oe, {"R3 output enable per bit period ", tag}, oe_bad, 0);
    if (poke) chk(frames == nexp, "R10 start while busy ignored", frames, nexp);
  endtask

  initial begin
    int hi;
    int full;
    logic [4:0] keep_a;
    logic keep_f;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !found && phy_addr == 0 && !mdio_oe, "R11 reset state",
        {busy, done, found, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mdio_oe, "R11 idle after reset", {busy, done, mdio_oe}, 0);

    // R4 MDC timing
    while (mdc) @(negedge clk);
    while (!mdc) @(negedge clk);
    hi = 0; full = 0;
    while (mdc) begin @(negedge clk); hi++; full++; end
    while (!mdc) begin @(negedge clk); full++; end
    chk(hi == DIV, "R4 mdc high time", hi, DIV);
    chk(full == 2 * DIV, "R4 mdc period", full, 2 * DIV);

    // R7: link only at 5, lower addresses report no link; start poked mid-scan (R10)
    fill(ABSENT);
    for (int a = 1; a <= 4; a++) begin st_first[a] = NOLINK; st_second[a] = NOLINK; end
    st_first[5] = LINKUP; st_second[5] = LINKUP;
    st_first[9] = LINKUP; st_second[9] = LINKUP;
    run_scan("link at 5", 1'b1, 5, 1'b1);

    // R9: result held while bus table changes and time passes
    keep_a = phy_addr; keep_f = found;
    fill(NOLINK);
    repeat (2000) @(negedge clk);
    chk(done && found == keep_f && phy_addr == keep_a && frames == 12,
        "R9 result held until start", phy_addr, keep_a);

    // R7: link at address 0
    fill(NOLINK);
    st_first[0] = LINKUP; st_second[0] = LINKUP;
    run_scan("link at 0", 1'b1, 0, 1'b0);

    // R5: second read decides
    fill(NOLINK);
    st_first[0] = ABSENT;  st_second[0] = ABSENT;
    st_first[2] = LINKUP;  st_second[2] = NOLINK;
    st_first[3] = NOLINK;  st_second[3] = LINKUP;
    st_first[7] = LINKUP;  st_second[7] = LINKUP;
    run_scan("R5 latched-low link", 1'b1, 3, 1'b0);

    // R6 and R8: absent PHYs (all ones) on even addresses, no link anywhere
    fill(NOLINK);
    for (int a = 0; a < 32; a += 2) begin st_first[a] = ABSENT; st_second[a] = ABSENT; end
    run_scan("R6 R8 no link", 1'b0, 0, 1'b0);

    // R6: only address 31 up, all others absent
    fill(ABSENT);
    st_first[31] = LINKUP; st_second[31] = LINKUP;
    run_scan("R6 link at 31", 1'b1, 31, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule